// File: doc/BRIEF.md
# Two-of-Three Pulse Gate

The block takes an asynchronous pulse train, for example an engine speed feed, and produces a train in which one pulse out of every three is removed. The output frequency is then two thirds of the input frequency at any input rate, with no tuning. Every pulse that survives keeps its own high time. A removed pulse adds its time to the low interval around it, so that interval appears as one long low period.

The raw input is first brought into the system clock domain by a short flop chain. A hold filter then accepts a new level only after the level has stayed stable for a set number of clocks. A phase counter with three states records where each pulse falls in its group. The counter moves only when the filter accepts a falling edge, so its state cannot change while a pulse is being passed or blocked. The output is a register: it carries the filtered level in the two passing phases and stays low in the dropping phase. Output edges therefore trail input edges by a fixed number of clocks.

Top module: `pulse_gate`

## Requirements
- R1: While rst is high, and on the first clock edge after it, pulseOut is low, and the phase counter sits in the dropping slot (slot 0).
- R2: Complete pulses after reset are numbered 1, 2, 3, and so on. Pulses 1, 4, 7 and every third pulse after them produce no output. All other pulses are reproduced on pulseOut.
- R3: The high time of each reproduced pulse, counted in clocks, equals the high time of the matching input pulse, provided every level is held for at least GLITCH_CYCLES clocks.
- R4: An output edge occurs on the (GLITCH_CYCLES+3)-th rising clock edge after the input change. With the default GLITCH_CYCLES=4 that is the 7th rising edge.
- R5: The filter ignores an input level held for fewer than GLITCH_CYCLES clocks. A short high blip between pulses creates no output and is not counted. A short low notch inside a pulse does not split it, so the pulse counts as one.
- R6: The phase counter changes only when the filter accepts a falling edge. When the counter wraps from slot 2 back to slot 0, no output pulse of any length appears.
- R7: If rst is released while the input is high, that partial pulse is neither output nor counted. Pulse 1 is the first pulse whose rising edge the filter accepts after reset.
- R8: For any mix of input periods spanning more than 10:1, n complete input pulses give n - ceil(n/3) output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulseIn | input | 1 | Raw asynchronous pulse train |
| pulseOut | output | 1 | Registered, gated pulse train |

## Verification
Every result appears at a fixed point: an output edge is due GLITCH_CYCLES+3 rising edges after the input change that caused it. The bench records the cycle of every input edge it drives and the cycle of every output edge it sees, sampling on falling clock edges. It then compares each output edge with the matching input edge plus that latency, computed from its own copy of the parameter. Drop and pass decisions, pulse counts and widths are worked out from the recorded input pulses only after the last edge of a segment has had the full latency plus a margin to settle.

// File: rtl/pulse_gate_pkg.sv
package pulse_gate_pkg;

  // Edge strobes sent from the datapath to the control
  typedef struct packed {
    logic riseStb;
    logic fallStb;
  } edge_t;

  // Strobe sent from the control to the datapath
  typedef struct packed {
    logic passEn;
  } ctrl_t;

endpackage

// File: rtl/pulse_gate_sync.sv
module pulse_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  // Reset to high, so a pulse already present at reset release looks like a
  // level that was always there rather than a fresh rising edge.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/pulse_gate_filter.sv
module pulse_gate_filter #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sampleIn,
  output logic levelOut
);

  localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic             accepted;
  logic             differs;

  assign differs = (sampleIn != accepted);

  // A differing sample must be seen on HOLD_CYCLES edges in a row
  always_ff @(posedge clk) begin
    if (rst) begin
      accepted <= 1'b1;
      holdCnt  <= '0;
    end else if (!differs) begin
      holdCnt  <= '0;
    end else if (holdCnt == LAST) begin
      accepted <= sampleIn;
      holdCnt  <= '0;
    end else begin
      holdCnt  <= holdCnt + 1'b1;
    end
  end

  assign levelOut = accepted;

endmodule

// File: rtl/pulse_gate_datapath.sv
module pulse_gate_datapath
  import pulse_gate_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pulseIn,
  input  ctrl_t ctrl,
  output edge_t edges,
  output logic  syncLvl,
  output logic  filtLvl,
  output logic  pulseOut
);

  logic filtPrev;
  logic outReg;

  pulse_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (pulseIn),
    .syncOut (syncLvl)
  );

  pulse_gate_filter #(.HOLD_CYCLES(GLITCH_CYCLES)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (syncLvl),
    .levelOut (filtLvl)
  );

  // Edge detection on the filtered level; the previous level resets high to match the filter
  always_ff @(posedge clk) begin
    if (rst) filtPrev <= 1'b1;
    else     filtPrev <= filtLvl;
  end

  always_comb begin
    edges.riseStb = filtLvl & ~filtPrev;
    edges.fallStb = ~filtLvl & filtPrev;
  end

  // Gated output register
  always_ff @(posedge clk) begin
    if (rst) outReg <= 1'b0;
    else     outReg <= filtLvl & ctrl.passEn;
  end

  assign pulseOut = outReg;

endmodule

// File: rtl/pulse_gate_control.sv
module pulse_gate_control
  import pulse_gate_pkg::*;
#(
  parameter int GROUP_LEN = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  edge_t                        edges,
  output ctrl_t                        ctrl,
  output logic [$clog2(GROUP_LEN)-1:0] phase,
  output logic                         armed
);

  localparam int PH_W = $clog2(GROUP_LEN);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP_LEN - 1);
  localparam logic [PH_W-1:0] PH_DROP = '0;

  logic [PH_W-1:0] phaseReg;
  logic            armedReg;
  logic            advance;

  // Counting starts only after a rising edge has been accepted since reset
  always_ff @(posedge clk) begin
    if (rst)                armedReg <= 1'b0;
    else if (edges.riseStb) armedReg <= 1'b1;
  end

  assign advance = edges.fallStb & armedReg;

  always_ff @(posedge clk) begin
    if (rst)                    phaseReg <= PH_DROP;
    else if (advance) begin
      if (phaseReg == PH_LAST)  phaseReg <= PH_DROP;
      else                      phaseReg <= phaseReg + 1'b1;
    end
  end

  always_comb ctrl.passEn = (phaseReg != PH_DROP);

  assign phase = phaseReg;
  assign armed = armedReg;

endmodule

// File: rtl/pulse_gate.sv
module pulse_gate
  import pulse_gate_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int GLITCH_CYCLES = 4,
  parameter int GROUP_LEN     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pulseIn,
  output logic pulseOut
);

  localparam int PH_W = $clog2(GROUP_LEN);

  edge_t           edges;
  ctrl_t           ctrl;
  logic            syncLvl;
  logic            filtLvl;
  logic [PH_W-1:0] phase;
  logic            armed;

  pulse_gate_datapath #(
    .SYNC_STAGES   (SYNC_STAGES),
    .GLITCH_CYCLES (GLITCH_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .pulseIn  (pulseIn),
    .ctrl     (ctrl),
    .edges    (edges),
    .syncLvl  (syncLvl),
    .filtLvl  (filtLvl),
    .pulseOut (pulseOut)
  );

  pulse_gate_control #(.GROUP_LEN(GROUP_LEN)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .edges (edges),
    .ctrl  (ctrl),
    .phase (phase),
    .armed (armed)
  );

endmodule

// File: rtl/pulse_gate_chk.sv
module pulse_gate_chk #(
  parameter int GROUP_LEN = 3
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         pulseOut,
  input logic                         syncLvl,
  input logic                         filtLvl,
  input logic                         fallStb,
  input logic                         passEn,
  input logic [$clog2(GROUP_LEN)-1:0] phase,
  input logic                         armed
);

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (!pulseOut && phase == '0));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fallStb |=> $stable(phase));

  // R6
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= ($clog2(GROUP_LEN))'(GROUP_LEN - 1));

  // R6
  no_runt_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulseOut) |-> !filtLvl);

  // R2
  rise_in_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseOut) |-> (passEn && filtLvl));

  // R7
  out_armed_chk: assert property (@(posedge clk) disable iff (rst)
    pulseOut |-> armed);

  // R5
  filt_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(filtLvl) |-> (filtLvl == $past(syncLvl)));

endmodule

bind pulse_gate pulse_gate_chk #(.GROUP_LEN(GROUP_LEN)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .pulseOut (pulseOut),
  .syncLvl  (syncLvl),
  .filtLvl  (filtLvl),
  .fallStb  (edges.fallStb),
  .passEn   (ctrl.passEn),
  .phase    (phase),
  .armed    (armed)
);

// File: tb/pulse_gate_tb_top.sv
module pulse_gate_tb_top;

  localparam int N   = 4;
  localparam int LAT = N + 3;
  localparam int MAXP = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulseIn = 1'b0;
  logic pulseOut;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int inRise[MAXP];
  int inFall[MAXP];
  int outRise[MAXP];
  int outFall[MAXP];
  int nIn = 0;
  int nOut = 0;
  logic prevOut = 1'b0;

  pulse_gate #(.SYNC_STAGES(2), .GLITCH_CYCLES(N), .GROUP_LEN(3)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .pulseIn  (pulseIn),
    .pulseOut (pulseOut)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Output edge recorder, sampled away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      nOut = 0;
      prevOut = 1'b0;
    end else begin
      if (pulseOut && !prevOut && nOut < MAXP) outRise[nOut] = cyc;
      if (!pulseOut && prevOut && nOut < MAXP) begin
        outFall[nOut] = cyc;
        nOut++;
      end
      prevOut = pulseOut;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expCount(input int n);
    return n - (n + 2) / 3;
  endfunction

  task automatic startSeg(input logic lvl);
    pulseIn = lvl;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: output low while in reset
    chk(pulseOut == 1'b0, "R1", "pulseOut in reset", int'(pulseOut), 0);
    nIn = 0;
    rst = 1'b0;
    @(negedge clk);
    // R1: output low on the first edge after reset
    chk(pulseOut == 1'b0, "R1", "pulseOut after reset", int'(pulseOut), 0);
    repeat (N + 6) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pulseIn = 1'b1;
    inRise[nIn] = cyc;
    repeat (hi) @(negedge clk);
    pulseIn = 1'b0;
    inFall[nIn] = cyc;
    nIn++;
    repeat (lo) @(negedge clk);
  endtask

  task automatic blip(input int w);
    pulseIn = 1'b1;
    repeat (w) @(negedge clk);
    pulseIn = 1'b0;
    repeat (N + 3) @(negedge clk);
  endtask

  task automatic notchPulse(input int a, input int w, input int b, input int lo);
    pulseIn = 1'b1;
    inRise[nIn] = cyc;
    repeat (a) @(negedge clk);
    pulseIn = 1'b0;
    repeat (w) @(negedge clk);
    pulseIn = 1'b1;
    repeat (b) @(negedge clk);
    pulseIn = 1'b0;
    inFall[nIn] = cyc;
    nIn++;
    repeat (lo) @(negedge clk);
  endtask

  task automatic checkSeg(input string tag);
    int k;
    repeat (LAT + 5) @(negedge clk);
    // R8: count of reproduced pulses
    chk(nOut == expCount(nIn), "R8", {tag, " output pulse count"}, nOut, expCount(nIn));
    k = 0;
    for (int j = 0; j < nIn; j++) begin
      if (j % 3 != 0 && k < nOut) begin
        // R2 and R4: the right pulse appears at the fixed latency
        chk(outRise[k] == inRise[j] + LAT, "R2/R4", {tag, " rise cycle"},
            outRise[k], inRise[j] + LAT);
        chk(outFall[k] == inFall[j] + LAT, "R4", {tag, " fall cycle"},
            outFall[k], inFall[j] + LAT);
        // R3: width kept
        chk(outFall[k] - outRise[k] == inFall[j] - inRise[j], "R3", {tag, " width"},
            outFall[k] - outRise[k], inFall[j] - inRise[j]);
        k++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h2f3a_91c7));

    // Random widths, fast and slow regimes mixed
    startSeg(1'b0);
    for (int i = 0; i < 30; i++) begin
      if ($urandom_range(1, 0) == 1) pulse($urandom_range(N + 3, N), $urandom_range(N + 3, N));
      else pulse($urandom_range(150, 40), $urandom_range(150, 40));
    end
    checkSeg("random");

    // R5: blips between pulses and notches inside pulses are ignored
    startSeg(1'b0);
    pulse(N, N);
    blip(N - 1);
    pulse(12, 10);
    notchPulse(6, N - 1, 6, 10);
    blip(1);
    pulse(N, 20);
    notchPulse(8, 2, 9, 12);
    blip(N - 1);
    pulse(15, 15);
    checkSeg("R5 glitch");

    // R7: reset released during a pulse
    startSeg(1'b1);
    repeat (20) @(negedge clk);
    pulseIn = 1'b0;
    repeat (LAT + 6) @(negedge clk);
    chk(nOut == 0, "R7", "partial pulse output", nOut, 0);
    chk(pulseOut == 1'b0, "R7", "level after partial pulse", int'(pulseOut), 0);
    for (int i = 0; i < 7; i++) pulse(10 + i, 12);
    checkSeg("R7 partial");

    // R8 and R6: sweep of periods over a wide range, exact minimum widths
    startSeg(1'b0);
    for (int i = 0; i < 9; i++) pulse(N, N);
    for (int i = 0; i < 9; i++) pulse(200, 200);
    for (int i = 0; i < 8; i++) pulse($urandom_range(60, N), $urandom_range(60, N));
    checkSeg("R6/R8 sweep");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule